// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor Register Block

This block holds the per-interrupt state of a shared interrupt distributor that serves up to eight processor interfaces. Software reaches it through a single-cycle word-addressed register port. Each access carries the index of the processor that makes it. For every interrupt the block keeps an enable bit, a pending bit, a trigger mode, an 8-bit priority and, for shared interrupts, a processor bitmask that says where the interrupt is routed.

The first 32 interrupt IDs are private. Each processor has its own copy of their enable, pending and trigger state, and the access index picks which copy a register access sees. IDs 0 to 15 are software-generated. A write to a dedicated register raises one of them in every processor named in a bitmask. IDs 32 and up are shared by all processors. They are fed by external request lines, each of which is either level- or edge-sensitive. For each processor the block drives a vector of the interrupts that are pending, enabled and routed to it. A downstream per-processor interface arbitrates among them.

`regAddr` is a word address. Reads are combinational. Writes take effect at the rising clock edge. `NUM_IRQS` is a multiple of 32 between 64 and 992.

Top module: `irq_distributor`

## Requirements
- R1: Enable-set words sit at 0x040+w and enable-clear words at 0x060+w, with w = n/32 and bit n mod 32. A 1 sets or clears that ID's enable, and a 0 bit has no effect. Reading either word returns the current enable bits.
- R2: Pending-set words sit at 0x080+w and pending-clear words at 0x0A0+w, with the same bit layout and write-1 semantics as R1. Reading either word returns the current pending bits.
- R3: For IDs 0 to 31 (word 0 of the R1, R2 and R6 groups, and configuration word 1), enable, pending and trigger state are kept once per processor, and `accCpu` selects the copy that is read or written. IDs 32 and up are shared.
- R4: Target words at 0x200+w hold byte (n mod 4) of word n/4 as a processor bitmask for ID n. Bits at or above `NUM_CPUS` read 0. Words 0 to 7 ignore writes, and each byte of them reads `1 << accCpu`.
- R5: Priority words at 0x100+w hold one 8-bit field per ID in byte (n mod 4) of word n/4. All bits can be read and written.
- R6: Configuration words at 0x300+w hold 2 bits per ID, for ID n at bits 2(n mod 16)+1 : 2(n mod 16) of word n/16. Bit 1 set means edge-triggered, and bit 0 reads 0. Word 0 (IDs 0 to 15) always reads 0xAAAAAAAA and ignores writes.
- R7: A write of (mask << 16) | id to 0x3C0, with id in bits [3:0] and mask in bits [23:16], sets pending for that id in the private copy of every processor k whose mask bit k is 1. Mask bits at or above `NUM_CPUS` are ignored.
- R8: The read-only word at 0x001 returns `NUM_IRQS/32 - 1` in bits [4:0] and `NUM_CPUS - 1` in bits [7:5]. All other bits are 0.
- R9: Bit 0 of the word at 0x000 gates forwarding. While it is 0, every bit of `cpuIrq` is 0, and the enable and pending state is kept unchanged.
- R10: Bit k*NUM_IRQS+n of `cpuIrq` is set when forwarding is on and ID n is enabled and pending. For n < 32 this uses processor k's private copy. For n >= 32 bit k of the ID's target field must also be set.
- R11: Shared line `srcIrq[n-32]` sets pending for ID n on every cycle it is high when the ID is level-triggered, and only on a 0-to-1 change between cycles when it is edge-triggered. If a pending-clear write lands in the same cycle, the set wins.
- R12: After reset, all enable, pending, priority, target and trigger bits and the forwarding bit are 0, and `cpuIrq` is 0.
- R13: Addresses outside the listed words, including group words at or beyond the configured ID count, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Write strobe for the current address |
| regAddr | input | 10 | Word address |
| regWdata | input | 32 | Write data |
| accCpu | input | CPU_W | Index of the accessing processor |
| regRdata | output | 32 | Combinational read data |
| srcIrq | input | NUM_IRQS-32 | Request lines of the shared IDs 32 and up |
| cpuIrq | output | NUM_CPUS*NUM_IRQS | Forwarded interrupts, processor-major |

## Verification
A shared request line and a pending-clear write to the same ID can land in the same clock cycle. This collision decides whether an interrupt is lost. The bench forces it directly: an edge-triggered ID is dropped low, and then its line rises in the very cycle a pending-clear word names it. The bench expects the ID to stay pending and forwarded. In the random phase, line toggles and clear writes to the shared words overlap freely. A reference model that applies the clear first and the line's set afterwards judges every cycle.

// File: rtl/irqdist_pkg.sv
package irqdist_pkg;
  localparam int ADDR_W = 10;

  localparam logic [ADDR_W-1:0] A_CTRL = 10'h000;
  localparam logic [ADDR_W-1:0] A_TYPE = 10'h001;
  localparam logic [ADDR_W-1:0] A_SGI  = 10'h3C0;

  localparam logic [4:0] G_EN_SET = 5'h02;
  localparam logic [4:0] G_EN_CLR = 5'h03;
  localparam logic [4:0] G_PD_SET = 5'h04;
  localparam logic [4:0] G_PD_CLR = 5'h05;
  localparam logic [1:0] G_PRI    = 2'h1;
  localparam logic [1:0] G_TGT    = 2'h2;
  localparam logic [3:0] G_CFG    = 4'hC;

  typedef struct packed {
    logic ctrlWr;
    logic enSet;
    logic enClr;
    logic pdSet;
    logic pdClr;
    logic priWr;
    logic tgtWr;
    logic cfgWr;
    logic sgiWr;
  } regStrobe_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_TYPE, SEL_EN, SEL_PD, SEL_PRI, SEL_TGT, SEL_CFG
  } rdSel_t;
endpackage

// File: rtl/irqdist_decode.sv
module irqdist_decode
  import irqdist_pkg::*;
#(
  parameter int NUM_IRQS = 64
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel,
  output logic [7:0]        wordIdx
);
  localparam int EN_WORDS  = NUM_IRQS / 32;
  localparam int PRI_WORDS = NUM_IRQS / 4;
  localparam int CFG_WORDS = NUM_IRQS / 16;

  always_comb begin
    strobe  = '0;
    rdSel   = SEL_NONE;
    wordIdx = '0;
    if (regAddr == A_CTRL) begin
      rdSel = SEL_CTRL;
      strobe.ctrlWr = regWr;
    end else if (regAddr == A_TYPE) begin
      rdSel = SEL_TYPE;
    end else if (regAddr == A_SGI) begin
      strobe.sgiWr = regWr;
    end else if (regAddr[9:8] == 2'b00) begin
      wordIdx = {3'b000, regAddr[4:0]};
      if (int'(regAddr[4:0]) < EN_WORDS) begin
        case (regAddr[9:5])
          G_EN_SET: begin rdSel = SEL_EN; strobe.enSet = regWr; end
          G_EN_CLR: begin rdSel = SEL_EN; strobe.enClr = regWr; end
          G_PD_SET: begin rdSel = SEL_PD; strobe.pdSet = regWr; end
          G_PD_CLR: begin rdSel = SEL_PD; strobe.pdClr = regWr; end
          default: ;
        endcase
      end
    end else if (regAddr[9:8] == G_PRI) begin
      wordIdx = regAddr[7:0];
      if (int'(regAddr[7:0]) < PRI_WORDS) begin
        rdSel = SEL_PRI;
        strobe.priWr = regWr;
      end
    end else if (regAddr[9:8] == G_TGT) begin
      wordIdx = regAddr[7:0];
      if (int'(regAddr[7:0]) < PRI_WORDS) begin
        rdSel = SEL_TGT;
        strobe.tgtWr = regWr;
      end
    end else if (regAddr[9:6] == G_CFG) begin
      wordIdx = {2'b00, regAddr[5:0]};
      if (int'(regAddr[5:0]) < CFG_WORDS) begin
        rdSel = SEL_CFG;
        strobe.cfgWr = regWr;
      end
    end
  end
endmodule

// File: rtl/irqdist_state.sv
module irqdist_state
  import irqdist_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobe_t                   strobe,
  input  rdSel_t                       rdSel,
  input  logic [7:0]                   wordIdx,
  input  logic [31:0]                  regWdata,
  input  logic [(NUM_CPUS>1 ? $clog2(NUM_CPUS) : 1)-1:0] accCpu,
  input  logic [NUM_IRQS-33:0]         srcIrq,
  output logic [31:0]                  regRdata,
  output logic [NUM_CPUS*NUM_IRQS-1:0] cpuIrq
);
  localparam int NUM_SPI = NUM_IRQS - 32;

  logic                               ctrlEn;
  logic [NUM_CPUS-1:0][31:0]          bankEn, bankEnNx, bankPd, bankPdNx;
  logic [NUM_CPUS-1:0][15:0]          bankEdge, bankEdgeNx;
  logic [NUM_SPI-1:0]                 shEn, shEnNx, shPd, shPdNx, shEdge, shEdgeNx, srcPrev;
  logic [NUM_IRQS-1:0][7:0]           pri, priNx;
  logic [NUM_SPI-1:0][NUM_CPUS-1:0]   tgt, tgtNx;
  logic [NUM_CPUS-1:0]                cpuOneHot;

  assign cpuOneHot = NUM_CPUS'(1) << accCpu;

  // next-state: software writes first, line-driven sets after (set wins)
  always_comb begin
    bankEnNx   = bankEn;
    bankPdNx   = bankPd;
    bankEdgeNx = bankEdge;
    shEnNx     = shEn;
    shPdNx     = shPd;
    shEdgeNx   = shEdge;
    priNx      = pri;
    tgtNx      = tgt;
    if (wordIdx == 8'd0) begin
      if (strobe.enSet) bankEnNx[accCpu] = bankEn[accCpu] | regWdata;
      if (strobe.enClr) bankEnNx[accCpu] = bankEn[accCpu] & ~regWdata;
      if (strobe.pdSet) bankPdNx[accCpu] = bankPd[accCpu] | regWdata;
      if (strobe.pdClr) bankPdNx[accCpu] = bankPd[accCpu] & ~regWdata;
    end
    if (strobe.cfgWr && wordIdx == 8'd1) begin
      for (int i = 0; i < 16; i++) bankEdgeNx[accCpu][i] = regWdata[2*i+1];
    end
    if (strobe.sgiWr) begin
      for (int k = 0; k < NUM_CPUS; k++) begin
        if (regWdata[16+k]) bankPdNx[k][regWdata[3:0]] = 1'b1;
      end
    end
    for (int i = 0; i < NUM_SPI; i++) begin
      if (int'(wordIdx) == i/32 + 1 && regWdata[i%32]) begin
        if (strobe.enSet) shEnNx[i] = 1'b1;
        if (strobe.enClr) shEnNx[i] = 1'b0;
        if (strobe.pdSet) shPdNx[i] = 1'b1;
        if (strobe.pdClr) shPdNx[i] = 1'b0;
      end
      if (strobe.cfgWr && int'(wordIdx) == (i+32)/16)
        shEdgeNx[i] = regWdata[2*((i+32)%16)+1];
      if (strobe.tgtWr && int'(wordIdx) == (i+32)/4)
        tgtNx[i] = regWdata[8*((i+32)%4) +: NUM_CPUS];
      if (shEdge[i] ? (srcIrq[i] && !srcPrev[i]) : srcIrq[i])
        shPdNx[i] = 1'b1;
    end
    for (int i = 0; i < NUM_IRQS; i++) begin
      if (strobe.priWr && int'(wordIdx) == i/4) priNx[i] = regWdata[8*(i%4) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      bankEn   <= '0;
      bankPd   <= '0;
      bankEdge <= '0;
      shEn     <= '0;
      shPd     <= '0;
      shEdge   <= '0;
      srcPrev  <= '0;
      pri      <= '0;
      tgt      <= '0;
    end else begin
      if (strobe.ctrlWr) ctrlEn <= regWdata[0];
      bankEn   <= bankEnNx;
      bankPd   <= bankPdNx;
      bankEdge <= bankEdgeNx;
      shEn     <= shEnNx;
      shPd     <= shPdNx;
      shEdge   <= shEdgeNx;
      srcPrev  <= srcIrq;
      pri      <= priNx;
      tgt      <= tgtNx;
    end
  end

  always_comb begin
    regRdata = '0;
    case (rdSel)
      SEL_CTRL: regRdata[0] = ctrlEn;
      SEL_TYPE: begin
        regRdata[4:0] = 5'(NUM_IRQS/32 - 1);
        regRdata[7:5] = 3'(NUM_CPUS - 1);
      end
      SEL_EN: begin
        if (wordIdx == 8'd0) regRdata = bankEn[accCpu];
        for (int i = 0; i < NUM_SPI; i++)
          if (int'(wordIdx) == i/32 + 1) regRdata[i%32] = shEn[i];
      end
      SEL_PD: begin
        if (wordIdx == 8'd0) regRdata = bankPd[accCpu];
        for (int i = 0; i < NUM_SPI; i++)
          if (int'(wordIdx) == i/32 + 1) regRdata[i%32] = shPd[i];
      end
      SEL_PRI: begin
        for (int i = 0; i < NUM_IRQS; i++)
          if (int'(wordIdx) == i/4) regRdata[8*(i%4) +: 8] = pri[i];
      end
      SEL_TGT: begin
        if (wordIdx < 8'd8) begin
          for (int b = 0; b < 4; b++) regRdata[8*b +: NUM_CPUS] = cpuOneHot;
        end
        for (int i = 0; i < NUM_SPI; i++)
          if (int'(wordIdx) == (i+32)/4) regRdata[8*((i+32)%4) +: NUM_CPUS] = tgt[i];
      end
      SEL_CFG: begin
        if (wordIdx == 8'd0) regRdata = 32'hAAAA_AAAA;
        if (wordIdx == 8'd1) begin
          for (int i = 0; i < 16; i++) regRdata[2*i+1] = bankEdge[accCpu][i];
        end
        for (int i = 0; i < NUM_SPI; i++)
          if (int'(wordIdx) == (i+32)/16) regRdata[2*((i+32)%16)+1] = shEdge[i];
      end
      default: regRdata = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_CPUS; k++) begin : g_cpu
    for (genvar n = 0; n < NUM_IRQS; n++) begin : g_id
      if (n < 32) begin : g_priv
        assign cpuIrq[k*NUM_IRQS+n] = ctrlEn & bankEn[k][n] & bankPd[k][n];
      end else begin : g_shared
        assign cpuIrq[k*NUM_IRQS+n] = ctrlEn & shEn[n-32] & shPd[n-32] & tgt[n-32][k];
      end
    end
  end

  AST_ENSET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enSet && wordIdx == 8'd0) |=>
      ((bankEn[$past(accCpu)] & $past(regWdata)) == $past(regWdata))); // R1
  AST_ENCLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enClr && wordIdx == 8'd0) |=>
      ((bankEn[$past(accCpu)] & $past(regWdata)) == 32'd0)); // R1
  AST_TGT_LOW_RO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tgtWr && wordIdx < 8'd8) |=> $stable(tgt)); // R4

  for (genvar k = 0; k < NUM_CPUS; k++) begin : g_sgiChk
    AST_SGI_PENDS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.sgiWr && regWdata[16+k]) |=> bankPd[k][$past(regWdata[3:0])]); // R7
  end
  for (genvar i = 0; i < NUM_SPI; i++) begin : g_edgeChk
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (shEdge[i] && srcIrq[i] && !srcPrev[i]) |=> shPd[i]); // R11
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqdist_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 64,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic [9:0]                   regAddr,
  input  logic [31:0]                  regWdata,
  input  logic [CPU_W-1:0]             accCpu,
  output logic [31:0]                  regRdata,
  input  logic [NUM_IRQS-33:0]         srcIrq,
  output logic [NUM_CPUS*NUM_IRQS-1:0] cpuIrq
);
  regStrobe_t strobe;
  rdSel_t     rdSel;
  logic [7:0] wordIdx;

  irqdist_decode #(.NUM_IRQS(NUM_IRQS)) u_decode (
    .regWr   (regWr),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .wordIdx (wordIdx)
  );

  irqdist_state #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_state (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .wordIdx  (wordIdx),
    .regWdata (regWdata),
    .accCpu   (accCpu),
    .srcIrq   (srcIrq),
    .regRdata (regRdata),
    .cpuIrq   (cpuIrq)
  );
endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int NC = 4;
  localparam int NI = 64;
  localparam int NS = NI - 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           regWr = 1'b0;
  logic [9:0]     regAddr = '0;
  logic [31:0]    regWdata = '0;
  logic [1:0]     accCpu = '0;
  logic [31:0]    regRdata;
  logic [NS-1:0]  srcIrq = '0;
  logic [NC*NI-1:0] cpuIrq;

  irq_distributor #(.NUM_CPUS(NC), .NUM_IRQS(NI)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .accCpu(accCpu), .regRdata(regRdata), .srcIrq(srcIrq), .cpuIrq(cpuIrq));

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model
  logic [31:0]   mEnB [NC];
  logic [31:0]   mPdB [NC];
  logic [15:0]   mEdB [NC];
  logic [NS-1:0] mEnS, mPdS, mEdS, mPrev, srcv;
  logic [7:0]    mPri [NI];
  logic [NC-1:0] mTgt [NS];
  logic          mCtrl;
  logic [31:0]   lastRd, lastExpRd;

  task automatic chk(input string tag, input logic [NC*NI-1:0] act, input logic [NC*NI-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [9:0] a, input int c);
    logic [31:0] r = '0;
    int w;
    if (a == 10'h000) r[0] = mCtrl;
    else if (a == 10'h001) r = 32'(NI/32 - 1) | (32'(NC - 1) << 5);
    else if (a >= 10'h040 && a < 10'h0C0) begin
      w = int'(a[4:0]);
      if (w < NI/32) begin
        if (w == 0) r = (a < 10'h080) ? mEnB[c] : mPdB[c];
        else for (int b = 0; b < 32; b++) r[b] = (a < 10'h080) ? mEnS[32*w+b-32] : mPdS[32*w+b-32];
      end
    end else if (a[9:8] == 2'h1) begin
      w = int'(a[7:0]);
      if (w < NI/4) for (int b = 0; b < 4; b++) r[8*b +: 8] = mPri[4*w+b];
    end else if (a[9:8] == 2'h2) begin
      w = int'(a[7:0]);
      if (w < 8) for (int b = 0; b < 4; b++) r[8*b +: NC] = NC'(1) << c;
      else if (w < NI/4) for (int b = 0; b < 4; b++) r[8*b +: NC] = mTgt[4*w+b-32];
    end else if (a[9:6] == 4'hC) begin
      w = int'(a[5:0]);
      if (w == 0) r = 32'hAAAA_AAAA;
      else if (w == 1) for (int i = 0; i < 16; i++) r[2*i+1] = mEdB[c][i];
      else if (w < NI/16) for (int i = 0; i < 16; i++) r[2*i+1] = mEdS[16*w+i-32];
    end
    return r;
  endfunction

  function automatic logic [NC*NI-1:0] expIrq();
    logic [NC*NI-1:0] v = '0;
    for (int k = 0; k < NC; k++)
      for (int n = 0; n < NI; n++)
        if (n < 32) v[k*NI+n] = mCtrl & mEnB[k][n] & mPdB[k][n];
        else v[k*NI+n] = mCtrl & mEnS[n-32] & mPdS[n-32] & mTgt[n-32][k];
    return v;
  endfunction

  task automatic modelStep(input logic wr, input logic [9:0] a, input logic [31:0] d, input int c);
    logic [NS-1:0] hw;
    int w;
    for (int i = 0; i < NS; i++) hw[i] = mEdS[i] ? (srcv[i] & ~mPrev[i]) : srcv[i];
    if (wr) begin
      if (a == 10'h000) mCtrl = d[0];
      else if (a >= 10'h040 && a < 10'h0C0) begin
        w = int'(a[4:0]);
        if (w == 0) begin
          case (a[9:5])
            5'h02: mEnB[c] = mEnB[c] | d;
            5'h03: mEnB[c] = mEnB[c] & ~d;
            5'h04: mPdB[c] = mPdB[c] | d;
            default: mPdB[c] = mPdB[c] & ~d;
          endcase
        end else if (w < NI/32) begin
          for (int b = 0; b < 32; b++) if (d[b]) begin
            case (a[9:5])
              5'h02: mEnS[32*w+b-32] = 1'b1;
              5'h03: mEnS[32*w+b-32] = 1'b0;
              5'h04: mPdS[32*w+b-32] = 1'b1;
              default: mPdS[32*w+b-32] = 1'b0;
            endcase
          end
        end
      end else if (a[9:8] == 2'h1) begin
        w = int'(a[7:0]);
        if (w < NI/4) for (int b = 0; b < 4; b++) mPri[4*w+b] = d[8*b +: 8];
      end else if (a[9:8] == 2'h2) begin
        w = int'(a[7:0]);
        if (w >= 8 && w < NI/4) for (int b = 0; b < 4; b++) mTgt[4*w+b-32] = d[8*b +: NC];
      end else if (a == 10'h3C0) begin
        for (int k = 0; k < NC; k++) if (d[16+k]) mPdB[k][d[3:0]] = 1'b1;
      end else if (a[9:6] == 4'hC) begin
        w = int'(a[5:0]);
        if (w == 1) for (int i = 0; i < 16; i++) mEdB[c][i] = d[2*i+1];
        else if (w >= 2 && w < NI/16) for (int i = 0; i < 16; i++) mEdS[16*w+i-32] = d[2*i+1];
      end
    end
    mPdS = mPdS | hw;
    mPrev = srcv;
  endtask

  // one bus cycle: read sampled before the edge, outputs checked after it (R10)
  task automatic cycle(input logic wr, input logic [9:0] a, input logic [31:0] d, input int c);
    @(negedge clk);
    regWr = wr; regAddr = a; regWdata = d; accCpu = 2'(c); srcIrq = srcv;
    #1;
    lastRd = regRdata;
    lastExpRd = expRead(a, c);
    modelStep(wr, a, d, c);
    @(posedge clk);
    #1;
    chk("R10 forwarded vector", cpuIrq, expIrq());
  endtask

  task automatic rdChk(input string tag, input logic [9:0] a, input int c, input logic [31:0] lit);
    cycle(1'b0, a, 32'd0, c);
    chk(tag, {224'd0, lastRd}, {224'd0, lit});
    chk({tag, " model"}, {224'd0, lastRd}, {224'd0, lastExpRd});
  endtask

  task automatic bitChk(input string tag, input int idx, input logic exp);
    chk(tag, {255'd0, cpuIrq[idx]}, {255'd0, exp});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mCtrl = 1'b0; mEnS = '0; mPdS = '0; mEdS = '0; mPrev = '0; srcv = '0;
    for (int k = 0; k < NC; k++) begin mEnB[k] = '0; mPdB[k] = '0; mEdB[k] = '0; end
    for (int i = 0; i < NI; i++) mPri[i] = '0;
    for (int i = 0; i < NS; i++) mTgt[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    #1 chk("R12 cpuIrq after reset", cpuIrq, '0);
    rdChk("R12 control after reset", 10'h000, 0, 32'h0);
    rdChk("R12 priority after reset", 10'h100, 1, 32'h0);
    rdChk("R8 type word", 10'h001, 0, 32'h0000_0061);
    rdChk("R4 private target word", 10'h203, 2, 32'h0404_0404);
    cycle(1'b1, 10'h203, 32'hFFFF_FFFF, 2);
    rdChk("R4 private target ignores write", 10'h203, 2, 32'h0404_0404);

    // R1 / R3 banked enable
    cycle(1'b1, 10'h040, 32'h0000_0005, 1);
    rdChk("R1 enable set readback", 10'h040, 1, 32'h0000_0005);
    rdChk("R3 other bank untouched", 10'h040, 0, 32'h0);
    cycle(1'b1, 10'h060, 32'h0000_0004, 1);
    cycle(1'b1, 10'h040, 32'h0000_0000, 1);
    rdChk("R1 clear and zero-write", 10'h060, 1, 32'h0000_0001);

    // R7 software interrupt
    cycle(1'b1, 10'h000, 32'h1, 0);
    cycle(1'b1, 10'h040, 32'h0000_0008, 0);
    cycle(1'b1, 10'h3C0, 32'h00F5_0003, 3);
    bitChk("R7 cpu0 sgi forwarded", 0*NI+3, 1'b1);
    bitChk("R7 cpu2 sgi not enabled", 2*NI+3, 1'b0);
    rdChk("R7 cpu2 pending bit", 10'h080, 2, 32'h0000_0008);
    rdChk("R7 cpu1 not addressed", 10'h080, 1, 32'h0);

    // R11 level line on ID 40 routed to cpu1
    cycle(1'b1, 10'h041, 32'h0000_0100, 0);
    cycle(1'b1, 10'h20A, 32'h0000_0002, 0);
    srcv[8] = 1'b1;
    cycle(1'b0, 10'h3FF, 32'h0, 0);
    bitChk("R11 level sets pending, cpu1", 1*NI+40, 1'b1);
    bitChk("R10 not routed to cpu0", 0*NI+40, 1'b0);
    srcv[8] = 1'b0;
    cycle(1'b1, 10'h0A1, 32'h0000_0100, 0);
    bitChk("R2 shared pending cleared", 1*NI+40, 1'b0);

    // R6 / R11 edge mode
    cycle(1'b1, 10'h302, 32'h0002_0000, 0);
    rdChk("R6 config readback", 10'h302, 3, 32'h0002_0000);
    srcv[8] = 1'b1;
    cycle(1'b0, 10'h3FF, 32'h0, 0);
    bitChk("R11 edge sets pending", 1*NI+40, 1'b1);
    cycle(1'b1, 10'h0A1, 32'h0000_0100, 0);
    bitChk("R11 held line no repend", 1*NI+40, 1'b0);
    srcv[8] = 1'b0;
    cycle(1'b0, 10'h3FF, 32'h0, 0);
    srcv[8] = 1'b1;
    cycle(1'b1, 10'h0A1, 32'h0000_0100, 0);
    bitChk("R11 edge beats same-cycle clear", 1*NI+40, 1'b1);

    // R9 forwarding gate
    cycle(1'b1, 10'h000, 32'h0, 0);
    chk("R9 gate off silences all", cpuIrq, '0);
    rdChk("R9 pending kept", 10'h081, 0, 32'h0000_0100);
    cycle(1'b1, 10'h000, 32'h1, 0);
    bitChk("R9 gate back on", 1*NI+40, 1'b1);

    // R6 fixed word, R5 priority, R13 unmapped
    cycle(1'b1, 10'h300, 32'h0, 0);
    rdChk("R6 fixed config word", 10'h300, 0, 32'hAAAA_AAAA);
    cycle(1'b1, 10'h105, 32'h1234_5678, 2);
    rdChk("R5 priority readback", 10'h105, 0, 32'h1234_5678);
    cycle(1'b1, 10'h3FF, 32'hFFFF_FFFF, 0);
    rdChk("R13 unmapped read", 10'h3FF, 0, 32'h0);
    cycle(1'b1, 10'h042, 32'hFFFF_FFFF, 0);
    rdChk("R13 enable word beyond range", 10'h042, 0, 32'h0);

    // random phase
    for (int t = 0; t < 800; t++) begin
      int r = int'($urandom % 9);
      int c = int'($urandom % NC);
      logic wr = ($urandom % 3) != 0;
      logic [31:0] d = $urandom;
      logic [9:0] a;
      string tag;
      srcv = $urandom;
      case (r)
        0: begin a = 10'h000; d = 32'(($urandom % 4) != 0); tag = "R9 control"; end
        1: begin a = 10'h040 + 10'($urandom % 3); tag = "R1 enable set"; end
        2: begin a = 10'h060 + 10'($urandom % 2); tag = "R1 enable clear"; end
        3: begin a = 10'h080 + 10'($urandom % 2); d = d & $urandom; tag = "R2 pending set"; end
        4: begin a = 10'h0A0 + 10'($urandom % 2); tag = "R2 pending clear"; end
        5: begin a = 10'h100 + 10'($urandom % 17); tag = "R5 priority"; end
        6: begin a = 10'h200 + 10'($urandom % 17); tag = "R4 target"; end
        7: begin a = 10'h300 + 10'($urandom % 5); tag = "R6 config"; end
        default: begin a = 10'h3C0; d = d & 32'h00FF_000F; tag = "R7 software"; end
      endcase
      cycle(wr, a, d, c);
      if (!wr) chk({tag, " random read"}, {224'd0, lastRd}, {224'd0, lastExpRd});
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule